// File: doc/BRIEF.md
# Packed Compare and Min/Max ALU

This block is a SIMD arithmetic unit for a 64-bit datapath. Each of its two operands is split into eight byte lanes, four halfword lanes or two word lanes, as a size code selects. Every lane is processed on its own with one operation per request. The operation can be a mask-producing comparison (equal, signed greater-than, unsigned greater-than), a signed or unsigned minimum or maximum, or a wrapping add or subtract.

With each result the block also produces a 32-bit status word. It holds a negative flag and a zero flag for every lane, and the bit positions depend on the lane size. A request is a one-cycle strobe. Result and status are captured into one output register and appear one cycle later. The output register keeps its value until the next request.

Top module: `simd_cmpmax_alu`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high after that edge for exactly one cycle and `result`/`status` carry that request's outputs. `out_valid` is low after every edge at which `in_valid` was low.
- R2: Operation codes 0 (equal), 1 (signed greater-than) and 2 (unsigned greater-than) compare A against B and write all ones into a lane when the condition holds and all zeros when it does not.
- R3: Operation codes 3 (signed min), 4 (unsigned min), 5 (signed max) and 6 (unsigned max) copy the chosen lane of A or B unchanged.
- R4: Operation code 7 gives A+B and code 8 gives A-B in each lane, modulo the lane width, and no carry or borrow crosses a lane boundary.
- R5: Size code 0 selects eight 8-bit lanes, 1 selects four 16-bit lanes and 2 selects two 32-bit lanes. Lane i occupies bits starting at i times the lane width.
- R6: For byte lanes, lane i's negative flag is status bit 4i+3 and its zero flag is status bit 4i+2.
- R7: For halfword lanes, lane i's negative flag is status bit 8i+7 and its zero flag is status bit 8i+6.
- R8: For word lanes, lane i's negative flag is status bit 16i+15 and its zero flag is status bit 16i+14.
- R9: A lane's negative flag equals the most significant bit of that lane's result. Its zero flag is set exactly when the whole lane result is zero. Every status bit that is not a flag position for the current size reads zero.
- R10: Size code 3 produces a zero result and a zero status word.
- R11: Operation codes 9 to 15 produce a zero result and a zero status word.
- R12: After synchronous reset `out_valid`, `result` and `status` are zero. Without a request, `result` and `status` keep their last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe, one cycle per operation |
| op | input | 4 | Operation code (0..8 legal) |
| size | input | 2 | Lane size code (0 byte, 1 halfword, 2 word, 3 illegal) |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| out_valid | output | 1 | High for one cycle when a new result is presented |
| result | output | 64 | Registered lane-wise result |
| status | output | 32 | Registered per-lane negative and zero flags |

## Verification
`result`, `status` and `out_valid` are all due one cycle after the edge that captures a request. None of them is visible in the capture cycle itself.

The bench drives a request on a falling edge and drops the strobe on the next falling edge. It then samples all three outputs at that same falling edge, half a cycle after the capturing edge. Hold behaviour is checked on later falling edges with no request: `out_valid` must be low and the other two outputs must keep their values.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

    localparam int DATA_W = 64;
    localparam int STAT_W = 32;
    localparam int NUM_SIZES = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } lane_size_e;

    typedef enum logic [3:0] {
        OP_EQ   = 4'd0,
        OP_GTS  = 4'd1,
        OP_GTU  = 4'd2,
        OP_MINS = 4'd3,
        OP_MINU = 4'd4,
        OP_MAXS = 4'd5,
        OP_MAXU = 4'd6,
        OP_ADD  = 4'd7,
        OP_SUB  = 4'd8
    } alu_op_e;

    localparam logic [3:0] OP_LAST = 4'd8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [STAT_W-1:0] flags;
    } alu_out_t;

    function automatic int lane_width(input int size_idx);
        return 8 << size_idx;
    endfunction

    function automatic logic op_is_compare(input logic [3:0] code);
        return code <= 4'd2;
    endfunction

    // true when each lane of r is either all zeros or all ones
    function automatic logic lanes_are_masks(input logic [DATA_W-1:0] r,
                                             input logic [1:0] sz);
        logic ok;
        int w;
        ok = 1'b1;
        w  = 8 << sz;
        for (int i = 0; i < DATA_W; i++) begin
            if (r[i] != r[(i / w) * w]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y
);

    logic signed_gt;
    logic unsigned_gt;

    always_comb begin
        signed_gt   = $signed(a) > $signed(b);
        unsigned_gt = a > b;
        case (op)
            OP_EQ:   y = (a == b)    ? '1 : '0;
            OP_GTS:  y = signed_gt   ? '1 : '0;
            OP_GTU:  y = unsigned_gt ? '1 : '0;
            OP_MINS: y = signed_gt   ? b : a;
            OP_MINU: y = unsigned_gt ? b : a;
            OP_MAXS: y = signed_gt   ? a : b;
            OP_MAXU: y = unsigned_gt ? a : b;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
    import simd_cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    localparam int LANES = DATA_W / W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        simd_lane_alu #(.W(W)) u_lane (
            .op (op),
            .a  (a[g*W +: W]),
            .b  (b[g*W +: W]),
            .y  (y[g*W +: W])
        );
    end

endmodule

// File: rtl/simd_flag_pack.sv
module simd_flag_pack
    import simd_cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [DATA_W-1:0] r,
    output logic [STAT_W-1:0] flags
);

    localparam int LANES  = DATA_W / W;
    localparam int STRIDE = STAT_W / LANES;

    always_comb begin
        flags = '0;
        for (int i = 0; i < LANES; i++) begin
            flags[STRIDE*i + STRIDE - 1] = r[W*i + W - 1];
            flags[STRIDE*i + STRIDE - 2] = ~|r[W*i +: W];
        end
    end

endmodule

// File: rtl/simd_cmpmax_alu.sv
module simd_cmpmax_alu
    import simd_cmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [3:0]  op,
    input  logic [1:0]  size,
    input  logic [63:0] opa,
    input  logic [63:0] opb,
    output logic        out_valid,
    output logic [63:0] result,
    output logic [31:0] status
);

    alu_op_e           op_e;
    logic [DATA_W-1:0] path_y [NUM_SIZES];
    logic [STAT_W-1:0] path_f [NUM_SIZES];
    alu_out_t          nxt;
    alu_out_t          q;
    logic              q_valid;

    assign op_e = alu_op_e'(op);

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int LW = lane_width(s);
        simd_lane_array #(.W(LW)) u_arr (
            .op (op_e),
            .a  (opa),
            .b  (opb),
            .y  (path_y[s])
        );
        simd_flag_pack #(.W(LW)) u_flags (
            .r     (path_y[s]),
            .flags (path_f[s])
        );
    end

    always_comb begin
        nxt = '0;
        if (op <= OP_LAST) begin
            case (lane_size_e'(size))
                SZ_BYTE: begin nxt.data = path_y[0]; nxt.flags = path_f[0]; end
                SZ_HALF: begin nxt.data = path_y[1]; nxt.flags = path_f[1]; end
                SZ_WORD: begin nxt.data = path_y[2]; nxt.flags = path_f[2]; end
                default: nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) q <= nxt;
        end
    end

    assign out_valid = q_valid;
    assign result    = q.data;
    assign status    = q.flags;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(status))); // R12

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(size) == 2'd3) |-> (result == '0 && status == '0)); // R10

    AST_MASK_LANES: assert property (@(posedge clk) disable iff (rst)
        (out_valid && op_is_compare($past(op)) && $past(size) != 2'd3)
        |-> lanes_are_masks(result, $past(size))); // R2

    AST_WORD_UNUSED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(size) == 2'd2)
        |-> ((status & ~32'hC000_C000) == '0)); // R9

    AST_BYTE_TOP_NFLAG: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(size) == 2'd0) |-> (status[31] == result[63])); // R6

endmodule

// File: tb/sim_simd_cmpmax_alu.sv
module sim_simd_cmpmax_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  size = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [31:0] status;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    simd_cmpmax_alu u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result), .status(status)
    );

    localparam int NPAT = 4;
    localparam logic [63:0] PAT_A [NPAT] = '{
        64'h0123_4567_89AB_CDEF, 64'h8000_7FFF_FF00_0001,
        64'hFFFF_FFFF_0000_0000, 64'h5A5A_A5A5_1234_1234 };
    localparam logic [63:0] PAT_B [NPAT] = '{
        64'hFEDC_BA98_7654_3210, 64'h7FFF_8000_00FF_0001,
        64'h0000_0001_FFFF_FFFF, 64'h5A5A_5AA5_1234_4321 };

    function automatic void ref_alu(input logic [3:0] o, input logic [1:0] s,
                                    input logic [63:0] a, input logic [63:0] b,
                                    output logic [63:0] r, output logic [31:0] f);
        int w, n, st;
        longint unsigned ua, ub, m, rl;
        longint sa, sb;
        r = '0;
        f = '0;
        if (s == 2'd3 || o > 4'd8) return;
        w  = 8 << s;
        n  = 64 / w;
        st = 32 / n;
        m  = (64'd1 << w) - 64'd1;
        for (int i = 0; i < n; i++) begin
            ua = (a >> (i * w)) & m;
            ub = (b >> (i * w)) & m;
            sa = longint'(ua);
            sb = longint'(ub);
            if (ua[w-1]) sa = sa - (longint'(1) << w);
            if (ub[w-1]) sb = sb - (longint'(1) << w);
            case (o)
                4'd0: rl = (ua == ub) ? m : 0;
                4'd1: rl = (sa > sb) ? m : 0;
                4'd2: rl = (ua > ub) ? m : 0;
                4'd3: rl = (sa < sb) ? ua : ub;
                4'd4: rl = (ua < ub) ? ua : ub;
                4'd5: rl = (sa > sb) ? ua : ub;
                4'd6: rl = (ua > ub) ? ua : ub;
                4'd7: rl = (ua + ub) & m;
                default: rl = (ua - ub) & m;
            endcase
            r = r | (64'(rl) << (i * w));
            f[st*i + st - 1] = rl[w-1];
            f[st*i + st - 2] = (rl == 0);
        end
    endfunction

    function automatic string op_tag(input logic [3:0] o, input logic [1:0] s);
        string t;
        if (o <= 4'd2)      t = "R2";
        else if (o <= 4'd6) t = "R3";
        else                t = "R4";
        case (s)
            2'd0:    t = {t, "/R5/R6/R9"};
            2'd1:    t = {t, "/R5/R7/R9"};
            default: t = {t, "/R5/R8/R9"};
        endcase
        return t;
    endfunction

    task automatic chk(input string tag, input logic [63:0] gr, input logic [63:0] er,
                       input logic [31:0] gs, input logic [31:0] es);
        checks++;
        if (gr !== er || gs !== es) begin
            failures++;
            $display("FAIL %s result=%h expected=%h status=%h expected=%h",
                     tag, gr, er, gs, es);
        end
    endtask

    task automatic chk_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b expected=%b", tag, got, exp);
        end
    endtask

    // request on a falling edge; outputs sampled one falling edge later
    task automatic drive(input logic [3:0] o, input logic [1:0] s,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        op = o; size = s; opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [63:0] er, hr;
        logic [31:0] es, hs;

        repeat (3) @(negedge clk);
        chk("R12 reset state", result, 64'h0, status, 32'h0);
        chk_bit("R12 reset out_valid", out_valid, 1'b0);
        rst = 1'b0;

        // table walk: every legal op and size over each pattern pair
        for (int p = 0; p < NPAT; p++) begin
            for (int s = 0; s < 3; s++) begin
                for (int o = 0; o <= 8; o++) begin
                    drive(4'(o), 2'(s), PAT_A[p], PAT_B[p]);
                    ref_alu(4'(o), 2'(s), PAT_A[p], PAT_B[p], er, es);
                    chk(op_tag(4'(o), 2'(s)), result, er, status, es);
                    chk_bit("R1 out_valid after request", out_valid, 1'b1);
                end
            end
        end

        // R2: signed versus unsigned compare on byte 0x80 vs 0x7F
        drive(4'd1, 2'd0, 64'h80, 64'h7F);
        chk("R2 gts byte", result, 64'h0, status, 32'h4444_4444);
        drive(4'd2, 2'd0, 64'h80, 64'h7F);
        chk("R2 gtu byte", result, 64'hFF, status, 32'h4444_4448);

        // R3: signed and unsigned max on byte -128 vs 1
        drive(4'd5, 2'd0, 64'h80, 64'h01);
        chk("R3 maxs byte", result, 64'h01, status, 32'h4444_4440);
        drive(4'd6, 2'd0, 64'h80, 64'h01);
        chk("R3 maxu byte", result, 64'h80, status, 32'h4444_4448);

        // R4: halfword add wrap without carry into next lane
        drive(4'd7, 2'd1, 64'h0000_0000_0001_FFFF, 64'h0000_0000_0000_0001);
        chk("R4 add halfword wrap", result, 64'h0000_0000_0001_0000,
            status, 32'h4040_0040);
        // R4/R8: word subtract borrow stays in lane 0
        drive(4'd8, 2'd2, 64'h0, 64'h1);
        chk("R4 R8 sub word borrow", result, 64'h0000_0000_FFFF_FFFF,
            status, 32'h4000_8000);

        // R10: illegal size
        drive(4'd0, 2'd3, 64'h1234, 64'h1234);
        chk("R10 illegal size", result, 64'h0, status, 32'h0);

        // R11: illegal op codes
        drive(4'd9, 2'd0, 64'h0, 64'h0);
        chk("R11 op 9", result, 64'h0, status, 32'h0);
        drive(4'd15, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        chk("R11 op 15", result, 64'h0, status, 32'h0);

        // R12/R1: hold while idle
        drive(4'd0, 2'd1, 64'hAAAA_0000_AAAA_0000, 64'hAAAA_0000_5555_0000);
        ref_alu(4'd0, 2'd1, 64'hAAAA_0000_AAAA_0000, 64'hAAAA_0000_5555_0000, hr, hs);
        chk("R2 R7 eq halfword", result, hr, status, hs);
        opa = 64'h0; opb = 64'hFFFF; op = 4'd7;
        repeat (2) @(negedge clk);
        chk_bit("R1 out_valid low when idle", out_valid, 1'b0);
        chk("R12 hold when idle", result, hr, status, hs);

        // R12: reset clears a held result
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R12 reset clears", result, 64'h0, status, 32'h0);

        summary();
    end

endmodule